// File: doc/BRIEF.md
# Parity-Predicting Adder/Subtractor

This block adds or subtracts two W-bit operands. Each operand arrives with a parity bit, and the block forecasts the parity of its result from those bits and the carries of its own ripple chain. The forecast is formed without looking at the sum. It is then compared against parity recomputed on the finished sum. If they disagree, or if either incoming parity bit does not match its word, the error flag rises.

The check is separable. The sum and carry-out leave the block exactly as an unprotected adder would deliver them, and the predicted parity comes out beside them as a separate check bit. A single flipped bit anywhere between the carry chain and the sum outputs is caught in the same cycle. The inputs are registered behind a valid strobe, and results appear one clock later.

A per-bit fault input corrupts the carry that reaches each sum bit. It lets a test environment confirm that the checker notices damage in the carry wiring.

Top module: `parity_pred_adder`

## Requirements
- R1: With sub=0 and in_valid=1, {carry_out, sum} one cycle later equals op_a + op_b + carry_in, computed in W+1 bits.
- R2: With sub=1 and in_valid=1, sum one cycle later equals op_a - op_b - carry_in modulo 2^W. carry_out is 1 exactly when op_a >= op_b + carry_in, so no borrow occurs.
- R3: A parity bit is correct when it equals the XOR of all bits of its word, so it is 1 for an odd count of ones. pred_par equals par_a XOR par_b XOR (sub AND W odd) XOR the XOR of the carries entering bits 0..W-1. Carry 0 is carry_in when sub=0 and NOT carry_in when sub=1. With correct operand parities, pred_par therefore equals the parity of the fault-free sum. Each wrong operand parity bit inverts pred_par.
- R4: With both operand parities correct and inj_carry all zero, err is 0 one cycle after an in_valid cycle.
- R5: If par_a or par_b is incorrect, err is 1 one cycle later, and sum and carry_out are still the arithmetic result of R1 or R2.
- R6: inj_carry[i]=1 inverts the carry delivered to sum bit i only. One cycle later, sum differs from the fault-free result in exactly bit i, carry_out and pred_par are unaffected, and err is 1.
- R7: out_valid equals in_valid delayed by one clock.
- R8: After a cycle with in_valid=0, sum, carry_out and pred_par keep their previous values and err is 0.
- R9: While rst_n is low, out_valid, sum, carry_out, pred_par and err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| par_a | input | 1 | Parity bit of op_a |
| par_b | input | 1 | Parity bit of op_b |
| carry_in | input | 1 | Carry-in for addition, borrow-in for subtraction |
| sub | input | 1 | 1 selects op_a - op_b |
| inj_carry | input | W | Fault injection: bit i inverts the carry delivered to sum bit i |
| out_valid | output | 1 | Result valid |
| sum | output | W | Sum or difference |
| carry_out | output | 1 | Carry out of the top bit (1 = no borrow when subtracting) |
| pred_par | output | 1 | Predicted parity of the result |
| err | output | 1 | Parity mismatch or bad operand parity |

## Verification
The bench drives carries that ripple across the whole width: all ones plus one, and all ones plus all ones with carry-in. A chain that drops a tap would predict the wrong parity there and raise err on good data. Subtraction is exercised at zero minus one and at equal operands, where the complement correction and the inverted borrow matter. A design that mishandled either would report a wrong carry_out or a false error. A single-bit fault is injected into each sum-side carry in turn; a checker that compared a prediction against itself would stay silent there. Operand parity faults and idle cycles are also applied, to show that the sum passes through untouched and that held outputs do not move.

// File: rtl/pp_pkg.sv
package pp_pkg;
  // majority of three: carry generation of one full-adder cell
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  // parity correction for inverting a word of the given width:
  // complementing an odd-width word inverts its parity
  function automatic logic invert_fix(input logic do_inv, input int width);
    return do_inv & (width % 2 == 1);
  endfunction

  // effective carry into bit 0: borrow-in is inverted for subtraction
  function automatic logic first_carry(input logic cin, input logic is_sub);
    return cin ^ is_sub;
  endfunction
endpackage

// File: rtl/pp_operand_prep.sv
module pp_operand_prep
  import pp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] b_in,
  input  logic         par_b_in,
  input  logic         cin,
  input  logic         is_sub,
  output logic [W-1:0] b_eff,
  output logic         par_b_eff,
  output logic         c0
);
  assign b_eff     = is_sub ? ~b_in : b_in;
  assign par_b_eff = par_b_in ^ invert_fix(is_sub, W);
  assign c0        = first_carry(cin, is_sub);
endmodule

// File: rtl/pp_ripple_chain.sv
module pp_ripple_chain
  import pp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c0,
  input  logic [W-1:0] inj,
  output logic [W-1:0] s,
  output logic [W:0]   carry
);
  assign carry[0] = c0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic c_to_sum;
    // the tap feeding the sum XOR may be corrupted; the chain itself is not
    assign c_to_sum   = carry[i] ^ inj[i];
    assign s[i]       = a[i] ^ b[i] ^ c_to_sum;
    assign carry[i+1] = maj3(a[i], b[i], carry[i]);
  end
endmodule

// File: rtl/pp_parity_predict.sv
module pp_parity_predict #(
  parameter int W = 16
) (
  input  logic         par_a,
  input  logic         par_b_eff,
  input  logic [W-1:0] carries_in,
  output logic         pred
);
  logic carry_par;
  assign carry_par = ^carries_in;
  assign pred      = par_a ^ par_b_eff ^ carry_par;
endmodule

// File: rtl/pp_parity_check.sv
module pp_parity_check #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         par_a,
  input  logic         par_b,
  input  logic [W-1:0] s,
  input  logic         pred,
  output logic         opnd_bad,
  output logic         sum_mismatch
);
  assign opnd_bad     = ((^a) != par_a) | ((^b) != par_b);
  assign sum_mismatch = (^s) != pred;
endmodule

// File: rtl/parity_pred_adder.sv
module parity_pred_adder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         par_a,
  input  logic         par_b,
  input  logic         carry_in,
  input  logic         sub,
  input  logic [W-1:0] inj_carry,
  output logic         out_valid,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         pred_par,
  output logic         err
);
  localparam int CW = W + 1;

  logic [W-1:0]  b_eff;
  logic          par_b_eff;
  logic          c0;
  logic [W-1:0]  sum_now;
  logic [CW-1:0] carry_vec;
  logic          pred_now;
  logic          opnd_bad_now;
  logic          mismatch_now;
  logic          fault_now;

  pp_operand_prep #(.W(W)) u_prep (
    .b_in(op_b), .par_b_in(par_b), .cin(carry_in), .is_sub(sub),
    .b_eff(b_eff), .par_b_eff(par_b_eff), .c0(c0)
  );

  pp_ripple_chain #(.W(W)) u_chain (
    .a(op_a), .b(b_eff), .c0(c0), .inj(inj_carry),
    .s(sum_now), .carry(carry_vec)
  );

  pp_parity_predict #(.W(W)) u_pred (
    .par_a(par_a), .par_b_eff(par_b_eff), .carries_in(carry_vec[W-1:0]),
    .pred(pred_now)
  );

  pp_parity_check #(.W(W)) u_chk_logic (
    .a(op_a), .b(op_b), .par_a(par_a), .par_b(par_b),
    .s(sum_now), .pred(pred_now),
    .opnd_bad(opnd_bad_now), .sum_mismatch(mismatch_now)
  );

  assign fault_now = opnd_bad_now | mismatch_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      carry_out <= 1'b0;
      pred_par  <= 1'b0;
      err       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      err       <= in_valid & fault_now;
      if (in_valid) begin
        sum       <= sum_now;
        carry_out <= carry_vec[W];
        pred_par  <= pred_now;
      end
    end
  end
endmodule

// File: rtl/pp_adder_chk.sv
module pp_adder_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         par_a,
  input logic         par_b,
  input logic         carry_in,
  input logic         sub,
  input logic [W-1:0] inj_carry,
  input logic         out_valid,
  input logic [W-1:0] sum,
  input logic         carry_out,
  input logic         pred_par,
  input logic         err
);
  logic clean_in;
  logic [W:0] add_ref;
  assign clean_in = (inj_carry == '0) && ((^op_a) == par_a) && ((^op_b) == par_b);
  assign add_ref  = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in};

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sub && inj_carry == '0) |=> ({carry_out, sum} == $past(add_ref)));

  // R4
  clean_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clean_in) |=> !err);

  // R6
  inj_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $onehot(inj_carry)) |=> err);

  // R3
  pred_matches_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err) |-> (pred_par == ^sum));

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(in_valid)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum) && $stable(carry_out) && $stable(pred_par) && !err));
endmodule

bind parity_pred_adder pp_adder_chk #(.W(W)) u_pp_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .par_a(par_a), .par_b(par_b), .carry_in(carry_in), .sub(sub),
  .inj_carry(inj_carry), .out_valid(out_valid), .sum(sum),
  .carry_out(carry_out), .pred_par(pred_par), .err(err)
);

// File: tb/sim_parity_pred_adder.sv
`timescale 1ns/1ps
module sim_parity_pred_adder;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, inj_carry = '0;
  logic         par_a = 1'b0, par_b = 1'b0, carry_in = 1'b0, sub = 1'b0;
  logic         out_valid, carry_out, pred_par, err;
  logic [W-1:0] sum;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  parity_pred_adder #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .par_a(par_a), .par_b(par_b), .carry_in(carry_in), .sub(sub),
    .inj_carry(inj_carry), .out_valid(out_valid), .sum(sum),
    .carry_out(carry_out), .pred_par(pred_par), .err(err)
  );

  // reference arithmetic, written as plain add / subtract
  function automatic logic [W:0] ref_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic cin, input logic s);
    logic [W:0] d;
    if (!s) return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    d = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    return {~d[W], d[W-1:0]};
  endfunction

  function automatic int popcount_par(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += v[i];
    return n % 2;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // apply one operation; pa_bad / pb_bad corrupt the supplied parity bits
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic cin,
                        input logic s, input bit pa_bad, input bit pb_bad,
                        input logic [W-1:0] inj, input string tag);
    logic [W:0] r;
    logic [W-1:0] exp_sum;
    logic exp_pred;
    bit exp_err;
    @(negedge clk);
    in_valid = 1'b1; op_a = a; op_b = b; carry_in = cin; sub = s; inj_carry = inj;
    par_a = popcount_par(a)[0] ^ pa_bad;
    par_b = popcount_par(b)[0] ^ pb_bad;
    r = ref_result(a, b, cin, s);
    exp_sum = r[W-1:0] ^ inj;
    exp_pred = popcount_par(r[W-1:0])[0] ^ pa_bad ^ pb_bad;
    exp_err = pa_bad || pb_bad || (popcount_par(inj) == 1);
    @(posedge clk); #1;
    check(out_valid == 1'b1, {tag, " R7 out_valid"}, {{W{1'b0}}, out_valid}, 1);
    check({carry_out, sum} == {r[W], exp_sum}, {tag, (s ? " R2" : " R1"), " result"},
          {carry_out, sum}, {r[W], exp_sum});
    check(pred_par == exp_pred, {tag, " R3 pred_par"}, {{W{1'b0}}, pred_par}, {{W{1'b0}}, exp_pred});
    check(err == exp_err, {tag, (exp_err ? " R5/R6 err" : " R4 err")}, {{W{1'b0}}, err},
          {{W{1'b0}}, exp_err});
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [W:0] held;
    logic hp;
    void'($urandom(32'd20240611));
    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    check({out_valid, carry_out, pred_par, err} == 4'b0 && sum == '0, "R9 reset",
          {carry_out, sum}, '0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    run_op('1, 16'h0001, 1'b0, 1'b0, 0, 0, '0, "full_ripple");
    run_op('1, '1, 1'b1, 1'b0, 0, 0, '0, "ones_ones_cin");
    run_op(16'h5555, 16'hAAAA, 1'b1, 1'b0, 0, 0, '0, "alternating");
    run_op(16'h0000, 16'h0001, 1'b0, 1'b1, 0, 0, '0, "zero_minus_one");
    run_op(16'h1234, 16'h1234, 1'b0, 1'b1, 0, 0, '0, "equal_sub");
    run_op(16'h1234, 16'h1234, 1'b1, 1'b1, 0, 0, '0, "equal_sub_borrow");

    // R5 operand parity faults
    run_op(16'hBEEF, 16'h0F0F, 1'b0, 1'b0, 1, 0, '0, "R5 bad_pa");
    run_op(16'hBEEF, 16'h0F0F, 1'b0, 1'b1, 0, 1, '0, "R5 bad_pb");
    run_op(16'h8001, 16'h7FFF, 1'b1, 1'b0, 1, 1, '0, "R5 both_bad");

    // R6 single carry fault on every bit position
    for (int i = 0; i < W; i++) begin
      run_op('1, 16'h0001, 1'b0, 1'b0, 0, 0, W'(1) << i, "R6 inj_bit");
      run_op(16'h5A5A, 16'h3C3C, 1'b1, 1'b1, 0, 0, W'(1) << i, "R6 inj_sub");
    end

    // R8 idle hold
    @(negedge clk);
    in_valid = 1'b0; op_a = 16'hFFFF; op_b = 16'h1111; inj_carry = 16'h0003;
    @(posedge clk); #1;
    held = {carry_out, sum}; hp = pred_par;
    check(out_valid == 1'b0 && err == 1'b0, "R7/R8 idle flags", {{W-1{1'b0}}, out_valid, err}, '0);
    @(negedge clk); op_a = 16'h0F0F; par_a = ~par_a;
    @(posedge clk); #1;
    check({carry_out, sum} == held && pred_par == hp && !err, "R8 hold", {carry_out, sum}, held);

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (n % 4 == 0) ? ~ra : W'($urandom);
      run_op(ra, rb, 1'($urandom), 1'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0,
             (($urandom % 6) == 0) ? W'(1) << ($urandom % W) : '0, "random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule